// File: doc/BRIEF.md
# Deflection Controller Serial Adjustment Register Bank

This block is the two-wire serial slave of a display deflection controller. It samples the clock and data lines with a fast system clock and passes each line through a synchronizer and a spike filter. From the filtered lines it detects start and stop conditions. It answers one fixed device address. In a write it takes a register pointer byte and then any number of data bytes, and it writes each data byte into a bank of adjustment registers and control bits. The pointer advances by one after every data byte.

A read transfer returns one status byte, supplied on an input port, and then the slave stays off the bus. The register contents leave the block as parallel buses for the deflection logic. The block drives the bus through an open-drain pull-down enable. A single synchronous, active-high power-on reset loads every register to its default.

Top module: `dfl_i2c_adjust`

## Requirements
- R1: While `rst` is high, and after it falls, every adjustment register reads 0x80, all 17 control bits read 0 and `sda_oe` is low.
- R2: A pulse on the SCL or SDA input that lasts fewer than `FILT_LEN` system clocks has no effect on the transfer or on the registers.
- R3: The first byte after a start is an address with the R/W bit in bit 0, sent MSB first. The bytes 0x8C (write) and 0x8D (read) are acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged, and the slave then ignores the bus until the next start.
- R4: In a write, the byte after the address loads the register pointer, and the byte after that is written to the register the pointer selects. Every such byte is acknowledged.
- R5: Each further data byte in the same write goes to the pointer plus one. The pointer wraps from 0xFF to 0x00.
- R6: Pointer values 0 to 15 select adjustment registers 0 to 15. Pointer 16 writes control bits 7:0, pointer 17 writes control bits 15:8, and pointer 18 writes control bit 16 from data bit 0. Pointers 19 to 255 write nothing, but the data byte is still acknowledged.
- R7: After 0x8D is acknowledged, the slave sends `status_byte` as captured at the address, MSB first. It then releases SDA for the rest of the transfer, even if the master acknowledges, so any further read byte is 0xFF.
- R8: A repeated start with no stop in between makes the next byte an address again, and a new pointer byte is required before any data byte.
- R9: A stop ends the transfer. Bytes clocked after a stop and before the next start are not acknowledged and write nothing.
- R10: `sda_oe` rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| status_byte | input | 8 | Byte returned by a read transfer |
| sda_oe | output | 1 | High pulls the data line low |
| adj_regs | output | 128 | Adjustment registers; register i occupies bits 8i+7:8i |
| ctrl_bits | output | 17 | Control bits |

## Verification
A wrong internal state shows at the ports within one byte. A pointer that is off by one, or a shift register that took an extra bit from a spike, puts a data byte into the wrong register. That error can be read on `adj_regs` or `ctrl_bits` as soon as the eighth clock of the byte has fallen. A wrong state in the transfer sequence shows as a missing or extra acknowledge on `sda_oe` in the ninth clock of that same byte. It can also show as a read byte other than `status_byte`, or as data written after an unmatched address or after a stop. The bench keeps a model of the whole register map and compares it after every transfer, so an error is caught before the next transfer starts.

// File: rtl/dfl_i2c_pkg.sv
package dfl_i2c_pkg;

    localparam logic [6:0] DEV_ADDR    = 7'h46;
    localparam int         ADJ_COUNT   = 16;
    localparam int         CTRL_WIDTH  = 17;
    localparam int         CTRL_BYTES  = (CTRL_WIDTH + 7) / 8;
    localparam int         CTRL_BASE   = ADJ_COUNT;
    localparam int         LAST_SUB    = CTRL_BASE + CTRL_BYTES - 1;
    localparam logic [7:0] ADJ_DEFAULT = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } eng_state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [7:0] b);
        return b[7:1] == DEV_ADDR;
    endfunction

    function automatic logic [7:0] adj_default(input int idx);
        return ADJ_DEFAULT + 8'(idx * 0);
    endfunction

endpackage

// File: rtl/dfl_i2c_filter.sv
module dfl_i2c_filter #(
    parameter int FILT_LEN = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_out
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_in};
            if (sync_q[1] == filt_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                filt_q <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign line_out = filt_q;
endmodule

// File: rtl/dfl_i2c_engine.sv
module dfl_i2c_engine
    import dfl_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [7:0] status_byte,
    output logic       sda_oe,
    output eng_state_e state_o,
    output logic       start_o,
    output logic       stop_o,
    output wr_req_t    wr_o,
    output logic [7:0] sub_o
);
    eng_state_e state_q, after_q;
    logic       scl_q, sda_q;
    logic [3:0] bitcnt_q;
    logic [7:0] rx_q, tx_q, sub_q;
    logic       have_sub_q;
    wr_req_t    wr_q;

    logic scl_rise, scl_fall, start_det, stop_det;

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q      <= 1'b1;
            sda_q      <= 1'b1;
            state_q    <= ST_IDLE;
            after_q    <= ST_RX;
            bitcnt_q   <= '0;
            rx_q       <= '0;
            tx_q       <= '0;
            sub_q      <= '0;
            have_sub_q <= 1'b0;
            wr_q       <= '0;
        end else begin
            scl_q   <= scl_f;
            sda_q   <= sda_f;
            wr_q.en <= 1'b0;
            if (start_det) begin
                state_q    <= ST_ADDR;
                bitcnt_q   <= '0;
                have_sub_q <= 1'b0;
            end else if (stop_det) begin
                state_q <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            rx_q     <= {rx_q[6:0], sda_f};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (scl_fall && bitcnt_q == 4'd8) begin
                            bitcnt_q <= '0;
                            state_q  <= ST_ACK;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit(rx_q)) begin
                                    after_q <= rx_q[0] ? ST_TX : ST_RX;
                                    tx_q    <= status_byte;
                                end else begin
                                    state_q <= ST_SKIP;
                                end
                            end else if (!have_sub_q) begin
                                sub_q      <= rx_q;
                                have_sub_q <= 1'b1;
                            end else begin
                                wr_q  <= '{en: 1'b1, addr: sub_q, data: rx_q};
                                sub_q <= sub_q + 1'b1;
                            end
                        end
                    end
                    ST_ACK: if (scl_fall) state_q <= after_q;
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt_q == 4'd7) begin
                                state_q <= ST_MACK;
                            end else begin
                                tx_q     <= {tx_q[6:0], 1'b0};
                                bitcnt_q <= bitcnt_q + 1'b1;
                            end
                        end
                    end
                    ST_MACK: if (scl_fall) state_q <= ST_SKIP;
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe  = (state_q == ST_ACK) | ((state_q == ST_TX) & ~tx_q[7]);
    assign state_o = state_q;
    assign start_o = start_det;
    assign stop_o  = stop_det;
    assign wr_o    = wr_q;
    assign sub_o   = sub_q;
endmodule

// File: rtl/dfl_i2c_regbank.sv
module dfl_i2c_regbank
    import dfl_i2c_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr,
    output logic [ADJ_COUNT*8-1:0]   adj_regs,
    output logic [CTRL_WIDTH-1:0]    ctrl_bits
);
    for (genvar i = 0; i < ADJ_COUNT; i++) begin : g_adj
        logic [7:0] reg_q;
        always_ff @(posedge clk) begin
            if (rst)
                reg_q <= adj_default(i);
            else if (wr.en && wr.addr == 8'(i))
                reg_q <= wr.data;
        end
        assign adj_regs[i*8 +: 8] = reg_q;
    end

    for (genvar b = 0; b < CTRL_WIDTH; b++) begin : g_ctrl
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (wr.en && wr.addr == 8'(CTRL_BASE + b / 8))
                bit_q <= wr.data[b % 8];
        end
        assign ctrl_bits[b] = bit_q;
    end
endmodule

// File: rtl/dfl_i2c_adjust.sv
module dfl_i2c_adjust
    import dfl_i2c_pkg::*;
#(
    parameter int FILT_LEN = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_in,
    input  logic                   sda_in,
    input  logic [7:0]             status_byte,
    output logic                   sda_oe,
    output logic [ADJ_COUNT*8-1:0] adj_regs,
    output logic [CTRL_WIDTH-1:0]  ctrl_bits
);
    logic [1:0] raw_lines, filt_lines;
    logic       scl_f, sda_f;
    eng_state_e eng_state;
    logic       start_det, stop_det;
    wr_req_t    wr_req;
    logic [7:0] sub_ptr;

    assign raw_lines = {sda_in, scl_in};

    for (genvar k = 0; k < 2; k++) begin : g_line
        dfl_i2c_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk      (clk),
            .rst      (rst),
            .line_in  (raw_lines[k]),
            .line_out (filt_lines[k])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    dfl_i2c_engine u_eng (
        .clk         (clk),
        .rst         (rst),
        .scl_f       (scl_f),
        .sda_f       (sda_f),
        .status_byte (status_byte),
        .sda_oe      (sda_oe),
        .state_o     (eng_state),
        .start_o     (start_det),
        .stop_o      (stop_det),
        .wr_o        (wr_req),
        .sub_o       (sub_ptr)
    );

    dfl_i2c_regbank u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_req),
        .adj_regs  (adj_regs),
        .ctrl_bits (ctrl_bits)
    );
endmodule

// File: rtl/dfl_i2c_adjust_chk.sv
module dfl_i2c_adjust_chk
    import dfl_i2c_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   scl_f,
    input logic                   sda_oe,
    input logic                   start_det,
    input logic                   stop_det,
    input eng_state_e             eng_state,
    input wr_req_t                wr_req,
    input logic [7:0]             sub_ptr,
    input logic [ADJ_COUNT*8-1:0] adj_regs,
    input logic [CTRL_WIDTH-1:0]  ctrl_bits
);
    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f); // R10

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ST_SKIP) |-> !sda_oe); // R3

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        wr_req.en |-> (sub_ptr == wr_req.addr + 8'd1)); // R5

    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_req.en && wr_req.addr > 8'(LAST_SUB)) |=> ($stable(adj_regs) && $stable(ctrl_bits))); // R6

    AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (eng_state == ST_ADDR)); // R8

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (eng_state == ST_IDLE)); // R9
endmodule

bind dfl_i2c_adjust dfl_i2c_adjust_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (scl_f),
    .sda_oe    (sda_oe),
    .start_det (start_det),
    .stop_det  (stop_det),
    .eng_state (eng_state),
    .wr_req    (wr_req),
    .sub_ptr   (sub_ptr),
    .adj_regs  (adj_regs),
    .ctrl_bits (ctrl_bits)
);

// File: tb/dfl_i2c_adjust_test.sv
`timescale 1ns/100ps
module dfl_i2c_adjust_test;
    localparam int FILT = 12;
    localparam int Q    = 40;
    localparam int H    = 80;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         m_scl = 1'b1;
    logic         m_sda = 1'b1;
    logic [7:0]   status = 8'h00;
    logic         sda_oe;
    logic [127:0] adj_regs;
    logic [16:0]  ctrl_bits;
    wire          sda_line = m_sda & ~sda_oe;

    int           n_chk = 0;
    int           n_bad = 0;
    int           oe_bad = 0;
    logic         oe_prev = 1'b0;
    logic [7:0]   exp_adj [16];
    logic [16:0]  exp_ctrl;

    always #2.5 clk = ~clk;

    dfl_i2c_adjust #(.FILT_LEN(FILT)) uut (
        .clk         (clk),
        .rst         (rst),
        .scl_in      (m_scl),
        .sda_in      (sda_line),
        .status_byte (status),
        .sda_oe      (sda_oe),
        .adj_regs    (adj_regs),
        .ctrl_bits   (ctrl_bits)
    );

    // R10 monitor: enable must never rise while the clock line is high
    always @(negedge clk) begin
        if (!rst && sda_oe && !oe_prev && m_scl) oe_bad++;
        oe_prev = sda_oe;
    end

    task automatic wc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 16; i++)
            chk(req, $sformatf("adj[%0d]", i), int'(adj_regs[i*8 +: 8]), int'(exp_adj[i]));
        chk(req, "ctrl", int'(ctrl_bits), int'(exp_ctrl));
    endtask

    function automatic void model_write(input logic [7:0] a, input logic [7:0] d);
        if (a < 8'd16)       exp_adj[a[3:0]] = d;
        else if (a == 8'd16) exp_ctrl[7:0]   = d;
        else if (a == 8'd17) exp_ctrl[15:8]  = d;
        else if (a == 8'd18) exp_ctrl[16]    = d[0];
    endfunction

    task automatic i2c_start();
        m_sda = 1'b1; wc(Q);
        m_scl = 1'b1; wc(Q);
        m_sda = 1'b0; wc(Q);
        m_scl = 1'b0; wc(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wc(Q);
        m_scl = 1'b1; wc(Q);
        m_sda = 1'b1; wc(Q);
    endtask

    // glitch: 0 none, 1 short SCL pulse while low, 2 short SDA flip while SCL high
    task automatic send_byte(input logic [7:0] b, input int glitch, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wc(Q);
            if (glitch == 1 && i == 4) begin
                m_scl = 1'b1; wc(FILT - 2);
                m_scl = 1'b0; wc(Q);
            end
            m_scl = 1'b1;
            if (glitch == 2 && i == 4) begin
                wc(20);
                m_sda = ~b[i]; wc(FILT - 2);
                m_sda = b[i];  wc(H - 20 - (FILT - 2));
            end else begin
                wc(H);
            end
            m_scl = 1'b0; wc(Q);
        end
        m_sda = 1'b1; wc(Q);
        m_scl = 1'b1; wc(Q);
        ack = ~sda_line; wc(Q);
        m_scl = 1'b0; wc(Q);
    endtask

    task automatic read_byte(input logic master_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wc(Q);
            m_scl = 1'b1; wc(Q);
            b[i] = sda_line; wc(Q);
            m_scl = 1'b0; wc(Q);
        end
        m_sda = ~master_ack; wc(Q);
        m_scl = 1'b1; wc(H);
        m_scl = 1'b0; wc(Q);
        m_sda = 1'b1;
    endtask

    task automatic wr_seq(input string req, input logic [7:0] sub, input int n,
                          input logic [7:0] base, input logic [7:0] step, input int glitch);
        logic ack;
        i2c_start();
        send_byte(8'h8C, 0, ack); chk("R3", "write address ack", int'(ack), 1);
        send_byte(sub, 0, ack);   chk("R4", "pointer ack", int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = base + 8'(k) * step;
            send_byte(d, glitch, ack);
            chk(req, "data ack", int'(ack), 1);
            model_write(sub + 8'(k), d);
        end
        i2c_stop();
        wc(10);
        check_all(req);
    endtask

    initial begin
        logic       ack;
        logic [7:0] rb;
        for (int i = 0; i < 16; i++) exp_adj[i] = 8'h80;
        exp_ctrl = '0;

        wc(10);
        chk("R1", "oe in reset", int'(sda_oe), 0);
        check_all("R1");
        rst = 1'b0;
        wc(20);
        check_all("R1");

        // single write
        wr_seq("R4", 8'h03, 1, 8'h5A, 8'h00, 0);
        // burst across the end of the adjustment bank into control bits and past them
        wr_seq("R6", 8'h0E, 6, 8'h11, 8'h33, 0);
        // full sweep of all adjustment registers in one burst
        wr_seq("R5", 8'h00, 16, 8'h07, 8'h1D, 0);
        // pointer wrap: 0xFE and 0xFF ignored, then register 0
        wr_seq("R5", 8'hFE, 3, 8'hE1, 8'h01, 0);
        // spike rejection on each line
        wr_seq("R2", 8'h09, 2, 8'h6C, 8'h11, 1);
        wr_seq("R2", 8'h0B, 1, 8'h93, 8'h00, 2);

        // foreign addresses
        i2c_start();
        send_byte(8'h8E, 0, ack); chk("R3", "foreign 0x8E ack", int'(ack), 0);
        send_byte(8'h02, 0, ack); chk("R3", "ignored pointer ack", int'(ack), 0);
        send_byte(8'h55, 0, ack); chk("R3", "ignored data ack", int'(ack), 0);
        i2c_stop();
        i2c_start();
        send_byte(8'h0C, 0, ack); chk("R3", "foreign 0x0C ack", int'(ack), 0);
        send_byte(8'h04, 0, ack);
        send_byte(8'hAA, 0, ack);
        i2c_stop();
        wc(10);
        check_all("R3");

        // read with master NACK
        status = 8'hC3;
        i2c_start();
        send_byte(8'h8D, 0, ack); chk("R3", "read address ack", int'(ack), 1);
        status = 8'h00;
        read_byte(1'b0, rb);      chk("R7", "status byte", int'(rb), 'hC3);
        i2c_stop();
        wc(10);
        chk("R7", "oe after read", int'(sda_oe), 0);
        // read with master ACK: second byte is released bus
        status = 8'h3C;
        i2c_start();
        send_byte(8'h8D, 0, ack); chk("R3", "read address ack", int'(ack), 1);
        read_byte(1'b1, rb);      chk("R7", "status byte", int'(rb), 'h3C);
        read_byte(1'b0, rb);      chk("R7", "second read byte", int'(rb), 'hFF);
        i2c_stop();
        wc(10);
        check_all("R7");

        // repeated start restarts with an address and a new pointer
        i2c_start();
        send_byte(8'h8C, 0, ack);
        send_byte(8'h05, 0, ack);
        i2c_start();
        send_byte(8'h8C, 0, ack); chk("R8", "address after restart ack", int'(ack), 1);
        send_byte(8'h07, 0, ack); chk("R8", "pointer after restart ack", int'(ack), 1);
        send_byte(8'h99, 0, ack); chk("R8", "data after restart ack", int'(ack), 1);
        model_write(8'h07, 8'h99);
        i2c_stop();
        wc(10);
        check_all("R8");

        // bytes after a stop with no new start
        i2c_start();
        send_byte(8'h8C, 0, ack);
        send_byte(8'h02, 0, ack);
        i2c_stop();
        m_scl = 1'b0; wc(Q);
        send_byte(8'h44, 0, ack); chk("R9", "byte after stop ack", int'(ack), 0);
        send_byte(8'h21, 0, ack); chk("R9", "byte after stop ack", int'(ack), 0);
        m_scl = 1'b1; wc(Q);
        wc(10);
        check_all("R9");

        chk("R10", "enable rises with clock high", oe_bad, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule